// File: doc/BRIEF.md
# Idle depth sequencer

This block moves one processor core from normal execution into an idle depth chosen by software, and brings it back when a wake event arrives. Idle depths are cumulative. Depth 1 stops instruction issue and gates the core clocks. Depth 2 also asks the chipset for consent to keep the core off the system bus. Depth 3 also switches off the core PLL. Depth 4 also drops the core supply to a level that only retains state. The deeper the depth, the more leakage it saves and the longer the way in and out takes.

Each power-saving measure is a request line with a defined place in the ladder. The bus, PLL and supply measures each have an acknowledge input that the platform returns once the change has taken effect. The sequencer climbs the ladder one rung at a time. It waits for each acknowledge before it requests the next rung. On wake it climbs back down in the opposite order, again waiting for each acknowledge to fall. The PLL circuit, the voltage regulator and the operating system's choice of depth sit outside the block. They appear only as the request and acknowledge pins.

Top module: `idle_depth_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every request output is low and `depth_now` is 0.
- R2: When the core is running (all requests low), a one-cycle `idle_req` with `idle_target` of 1 or more and no `wake` raises `halt` at the next clock edge. It raises `clk_gate` one edge later. With target 1, the sequencer stops at `halt` and `clk_gate`.
- R3: For a target of 2 or more, `bus_quiet_req` rises one edge after `clk_gate`.
- R4: For a target of 3 or more, `pll_off_req` rises at the edge after the first edge at which `bus_grant` is sampled high.
- R5: For a target of 4 or more, `vret_req` rises at the edge after the first edge at which `pll_off_ack` is sampled high.
- R6: Every edge changes at most one request output. A rung is requested only once every acknowledge matches its request.
- R7: A `wake` pulse in a settled idle depth lowers the requests one per edge, from deepest to shallowest. It waits for each acknowledge to fall before lowering the next request. `clk_gate` falls one edge before `halt`.
- R8: A `wake` during entry requests no further rung. A handshake already in flight completes first, and the block then returns to running along the R7 order.
- R9: `idle_req` has no effect in three cases: the target is 0, the core is already idle or in transition, or it arrives together with `wake`. `wake` has no effect while the core is running.
- R10: A target above 4 (5, 6 or 7 on the 3-bit input) is treated as 4.
- R11: `depth_now` reads 0 when `clk_gate` is low. Otherwise it reads the deepest depth whose request lines are all high: 1 = halt+gate, 2 = +bus, 3 = +PLL, 4 = +supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Software request to go idle, sampled while running |
| idle_target | input | TGT_W (3) | Requested idle depth, 0..7, clamped to 4 |
| wake | input | 1 | Break event (interrupt or similar) |
| bus_grant | input | 1 | Chipset consent that the bus may stay quiet; follows `bus_quiet_req` |
| pll_off_ack | input | 1 | PLL is off; follows `pll_off_req` |
| vret_ack | input | 1 | Supply is at retention level; follows `vret_req` |
| halt | output | 1 | Stop instruction issue |
| clk_gate | output | 1 | Gate core clocks |
| bus_quiet_req | output | 1 | Ask chipset to keep the bus idle |
| pll_off_req | output | 1 | Ask for the core PLL to stop |
| vret_req | output | 1 | Ask for retention supply level |
| depth_now | output | 3 | Current idle depth, encoded as in R11 |

## Verification
The bench plays the chipset, PLL and regulator with programmable delays. It can freeze each acknowledge to expose any step that moves ahead without its handshake. A design that ignores an acknowledge would raise the PLL or supply request early, or drop a shallower request while a deeper acknowledge is still high. A wake arriving while the PLL handshake is pending would catch a design that keeps climbing to the supply rung, or one that abandons the handshake. The bench also covers a zero target, an out-of-range target, and a wake that collides with the idle request. It catches a design that halts when told not to, stops one rung short of the clamp, or lets the idle request win the collision.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

    localparam int STEP_W  = 3;
    localparam int DEPTH_W = 3;
    localparam int N_MEAS  = 5;
    localparam int N_FREE  = 2;   // rungs without handshake: halt, clock gate

    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [DEPTH_W-1:0] depth_t;
    typedef logic [N_MEAS-1:0]  meas_vec_t;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_ENTER = 2'd1,
        PH_EXIT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic vret;
        logic pll;
        logic bus;
        logic gate;
        logic halt;
    } meas_t;

    localparam step_t RUNG_GATE = step_t'(2);

    function automatic step_t steps_for(input depth_t d);
        return step_t'(d) + step_t'(1);
    endfunction

    function automatic depth_t depth_of(input step_t s);
        return (s < RUNG_GATE) ? '0 : depth_t'(s - step_t'(1));
    endfunction

endpackage

// File: rtl/idle_goal_reg.sv
module idle_goal_reg
    import idle_seq_pkg::*;
#(
    parameter int TGT_W     = 3,
    parameter int MAX_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TGT_W-1:0] target,
    output logic             target_nz,
    output step_t            goal_steps
);
    localparam logic [TGT_W-1:0] LIM = TGT_W'(MAX_DEPTH);

    depth_t clamped;

    always_comb begin
        if (target > LIM) clamped = depth_t'(MAX_DEPTH);
        else              clamped = depth_t'(target);
    end

    assign target_nz = |target;

    always_ff @(posedge clk) begin
        if (rst)       goal_steps <= '0;
        else if (load) goal_steps <= steps_for(clamped);
    end
endmodule

// File: rtl/idle_step_ctrl.sv
module idle_step_ctrl
    import idle_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   idle_req,
    input  logic   target_nz,
    input  logic   wake,
    input  logic   settled,
    input  step_t  goal_steps,
    output step_t  step,
    output phase_e phase,
    output logic   start
);
    step_t  step_n;
    phase_e phase_n;

    assign start = (phase == PH_RUN) && idle_req && target_nz && !wake;

    always_comb begin
        step_n  = step;
        phase_n = phase;
        unique case (phase)
            PH_RUN: begin
                if (start) begin
                    step_n  = step_t'(1);
                    phase_n = PH_ENTER;
                end
            end
            PH_ENTER: begin
                if (wake) begin
                    phase_n = PH_EXIT;
                    if (settled) begin
                        step_n = step - step_t'(1);
                        if (step == step_t'(1)) phase_n = PH_RUN;
                    end
                end else if (settled && (step < goal_steps)) begin
                    step_n = step + step_t'(1);
                end
            end
            PH_EXIT: begin
                if (settled) begin
                    step_n = step - step_t'(1);
                    if (step == step_t'(1)) phase_n = PH_RUN;
                end
            end
            default: begin
                step_n  = '0;
                phase_n = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= '0;
            phase <= PH_RUN;
        end else begin
            step  <= step_n;
            phase <= phase_n;
        end
    end
endmodule

// File: rtl/idle_meas_decode.sv
module idle_meas_decode
    import idle_seq_pkg::*;
(
    input  step_t                   step,
    input  logic [N_MEAS-N_FREE-1:0] acks,
    output meas_t                   meas,
    output logic                    settled,
    output depth_t                  depth
);
    meas_vec_t req_vec;
    meas_vec_t match;

    generate
        for (genvar k = 0; k < N_MEAS; k++) begin : g_rung
            assign req_vec[k] = (step > step_t'(k));
            if (k < N_FREE) begin : g_free
                assign match[k] = 1'b1;
            end else begin : g_hs
                assign match[k] = (acks[k-N_FREE] == req_vec[k]);
            end
        end
    endgenerate

    assign meas    = meas_t'(req_vec);
    assign settled = &match;
    assign depth   = depth_of(step);
endmodule

// File: rtl/idle_depth_seq.sv
module idle_depth_seq
    import idle_seq_pkg::*;
#(
    parameter int TGT_W     = 3,
    parameter int MAX_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_req,
    input  logic [TGT_W-1:0] idle_target,
    input  logic             wake,
    input  logic             bus_grant,
    input  logic             pll_off_ack,
    input  logic             vret_ack,
    output logic             halt,
    output logic             clk_gate,
    output logic             bus_quiet_req,
    output logic             pll_off_req,
    output logic             vret_req,
    output logic [2:0]       depth_now
);
    step_t  step;
    step_t  goal_steps;
    phase_e phase;
    logic   start;
    logic   target_nz;
    logic   settled;
    meas_t  meas;
    depth_t depth;

    idle_goal_reg #(.TGT_W(TGT_W), .MAX_DEPTH(MAX_DEPTH)) u_goal (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .target     (idle_target),
        .target_nz  (target_nz),
        .goal_steps (goal_steps)
    );

    idle_step_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .idle_req   (idle_req),
        .target_nz  (target_nz),
        .wake       (wake),
        .settled    (settled),
        .goal_steps (goal_steps),
        .step       (step),
        .phase      (phase),
        .start      (start)
    );

    idle_meas_decode u_dec (
        .step    (step),
        .acks    ({vret_ack, pll_off_ack, bus_grant}),
        .meas    (meas),
        .settled (settled),
        .depth   (depth)
    );

    assign halt          = meas.halt;
    assign clk_gate      = meas.gate;
    assign bus_quiet_req = meas.bus;
    assign pll_off_req   = meas.pll;
    assign vret_req      = meas.vret;
    assign depth_now     = 3'(depth);
endmodule

// File: rtl/idle_depth_seq_chk.sv
module idle_depth_seq_chk #(
    parameter int TGT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             idle_req,
    input logic [TGT_W-1:0] idle_target,
    input logic             wake,
    input logic             bus_grant,
    input logic             pll_off_ack,
    input logic             vret_ack,
    input logic             halt,
    input logic             clk_gate,
    input logic             bus_quiet_req,
    input logic             pll_off_req,
    input logic             vret_req,
    input logic [2:0]       depth_now
);
    logic [4:0] reqs;
    assign reqs = {vret_req, pll_off_req, bus_quiet_req, clk_gate, halt};

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (reqs == 5'b0 && depth_now == 3'd0));

    a_r2_gate_needs_halt: assert property (@(posedge clk) disable iff (rst)
        clk_gate |-> halt);

    a_r3_bus_needs_gate: assert property (@(posedge clk) disable iff (rst)
        bus_quiet_req |-> clk_gate);

    a_r4_pll_after_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_off_req) |-> ($past(bus_grant) && bus_quiet_req));

    a_r5_vret_after_pll_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(vret_req) |-> ($past(pll_off_ack) && pll_off_req));

    a_r6_one_rung_per_edge: assert property (@(posedge clk) disable iff (rst)
        $countones(reqs ^ $past(reqs)) <= 1);

    a_r7_pll_drop_after_vret: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_off_req) |-> (!$past(vret_ack) && !vret_req));

    a_r7_bus_drop_after_pll: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_quiet_req) |-> (!$past(pll_off_ack) && !pll_off_req));

    a_r9_zero_target_ignored: assert property (@(posedge clk) disable iff (rst)
        (!halt && idle_req && idle_target == '0) |=> !halt);

    a_r9_wake_while_running: assert property (@(posedge clk) disable iff (rst)
        (!halt && wake) |=> !halt);

    a_r11_depth_needs_gate: assert property (@(posedge clk) disable iff (rst)
        (depth_now != 3'd0) |-> clk_gate);
endmodule

bind idle_depth_seq idle_depth_seq_chk #(.TGT_W(TGT_W)) u_chk (.*);

// File: tb/idle_depth_seq_test.sv
module idle_depth_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_req = 1'b0;
    logic [2:0] idle_target = 3'd0;
    logic       wake = 1'b0;
    logic       bus_grant = 1'b0;
    logic       pll_off_ack = 1'b0;
    logic       vret_ack = 1'b0;
    logic       halt, clk_gate, bus_quiet_req, pll_off_req, vret_req;
    logic [2:0] depth_now;

    int n_checks = 0;
    int n_fail = 0;

    // responder settings, written by the stimulus
    int  d_bus = 0, d_pll = 0, d_v = 0;
    bit  s_bus = 0, s_pll = 0, s_v = 0;
    int  c_bus = 0, c_pll = 0, c_v = 0;

    // reference model state
    int  m_rung = 0;
    int  m_goal = 0;
    bit  m_leave = 0;
    bit  armed = 0;
    bit  vret_seen = 0;

    always #10 clk = ~clk;

    idle_depth_seq uut (
        .clk(clk), .rst(rst), .idle_req(idle_req), .idle_target(idle_target),
        .wake(wake), .bus_grant(bus_grant), .pll_off_ack(pll_off_ack),
        .vret_ack(vret_ack), .halt(halt), .clk_gate(clk_gate),
        .bus_quiet_req(bus_quiet_req), .pll_off_req(pll_off_req),
        .vret_req(vret_req), .depth_now(depth_now)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference: per negedge compare, move the platform acks, then step the model.
    always @(negedge clk) begin
        bit ok_all;
        int exp_depth;
        int tgt;
        if (armed) begin
            exp_depth = (m_rung < 2) ? 0 : m_rung - 1;
            check(halt === (m_rung >= 1), "R2,R7 halt", halt, m_rung >= 1);
            check(clk_gate === (m_rung >= 2), "R2,R6,R7 clk_gate", clk_gate, m_rung >= 2);
            check(bus_quiet_req === (m_rung >= 3), "R3,R6 bus_quiet_req", bus_quiet_req, m_rung >= 3);
            check(pll_off_req === (m_rung >= 4), "R4,R6,R8 pll_off_req", pll_off_req, m_rung >= 4);
            check(vret_req === (m_rung >= 5), "R5,R8 vret_req", vret_req, m_rung >= 5);
            check(depth_now === 3'(exp_depth), "R11 depth_now", depth_now, exp_depth);
        end
        if (vret_req) vret_seen = 1;

        if (bus_quiet_req !== bus_grant && !s_bus) begin
            if (c_bus >= d_bus) begin bus_grant = bus_quiet_req; c_bus = 0; end
            else c_bus++;
        end else c_bus = 0;
        if (pll_off_req !== pll_off_ack && !s_pll) begin
            if (c_pll >= d_pll) begin pll_off_ack = pll_off_req; c_pll = 0; end
            else c_pll++;
        end else c_pll = 0;
        if (vret_req !== vret_ack && !s_v) begin
            if (c_v >= d_v) begin vret_ack = vret_req; c_v = 0; end
            else c_v++;
        end else c_v = 0;

        if (rst) begin
            m_rung = 0; m_goal = 0; m_leave = 0; armed = 1;
        end else begin
            ok_all = (bus_grant == (m_rung >= 3)) && (pll_off_ack == (m_rung >= 4))
                     && (vret_ack == (m_rung >= 5));
            if (m_rung == 0) begin
                tgt = int'(idle_target);
                if (idle_req && tgt != 0 && !wake) begin
                    m_goal = (tgt > 4) ? 4 : tgt;
                    m_rung = 1;
                end
            end else begin
                if (wake) m_leave = 1;
                if (m_leave) begin
                    if (ok_all) m_rung--;
                    if (m_rung == 0) m_leave = 0;
                end else if (ok_all && m_rung < m_goal + 1) begin
                    m_rung++;
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic pulse_idle(input int t, input bit with_wake);
        @(posedge clk); #2;
        idle_req = 1; idle_target = 3'(t); wake = with_wake;
        @(posedge clk); #2;
        idle_req = 0; wake = 0;
    endtask

    task automatic pulse_wake();
        @(posedge clk); #2;
        wake = 1;
        @(posedge clk); #2;
        wake = 0;
    endtask

    task automatic all_low(input string tag);
        check({halt, clk_gate, bus_quiet_req, pll_off_req, vret_req} == 5'b0, tag,
              {halt, clk_gate, bus_quiet_req, pll_off_req, vret_req}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        all_low("R1 outputs in reset");
        check(depth_now == 0, "R1 depth in reset", depth_now, 0);
        @(posedge clk); #2; rst = 0;
        tick(1);
        all_low("R1 outputs after reset");

        // depth 1
        pulse_idle(1, 0);
        tick(8);
        check(depth_now == 1, "R2 settle at depth 1", depth_now, 1);
        check(bus_quiet_req == 0, "R2 no bus request at depth 1", bus_quiet_req, 0);
        // new request while idle is ignored
        pulse_idle(4, 0);
        tick(20);
        check(depth_now == 1, "R9 idle_req while idle ignored", depth_now, 1);
        pulse_wake();
        tick(5);
        all_low("R7 back to running from depth 1");

        // depth 2 with slow chipset
        d_bus = 3;
        pulse_idle(2, 0);
        tick(15);
        check(depth_now == 2, "R3 settle at depth 2", depth_now, 2);
        pulse_wake();
        tick(15);
        all_low("R7 exit from depth 2");

        // depth 3
        d_bus = 1; d_pll = 4;
        pulse_idle(3, 0);
        tick(20);
        check(depth_now == 3, "R4 settle at depth 3", depth_now, 3);
        pulse_wake();
        tick(25);
        all_low("R7 exit from depth 3");

        // depth 4 with mixed delays
        d_bus = 2; d_pll = 3; d_v = 1;
        pulse_idle(4, 0);
        tick(25);
        check(depth_now == 4, "R5 settle at depth 4", depth_now, 4);
        // regulator stuck: exit must wait on the supply rung
        s_v = 1;
        pulse_wake();
        tick(12);
        check(vret_req == 0, "R7 supply request dropped first", vret_req, 0);
        check(pll_off_req == 1, "R7 PLL request held until supply ack falls", pll_off_req, 1);
        s_v = 0;
        tick(25);
        all_low("R7 exit from depth 4");

        // out-of-range target
        d_bus = 0; d_pll = 0; d_v = 0;
        pulse_idle(7, 0);
        tick(20);
        check(depth_now == 4, "R10 target 7 clamps to 4", depth_now, 4);
        check(vret_req == 1, "R10 supply rung reached", vret_req, 1);
        pulse_wake();
        tick(20);
        all_low("R7 exit after clamp");

        pulse_idle(5, 0);
        tick(20);
        check(depth_now == 4, "R10 target 5 clamps to 4", depth_now, 4);
        pulse_wake();
        tick(20);

        // wake during entry while PLL handshake pending
        d_pll = 8;
        vret_seen = 0;
        pulse_idle(4, 0);
        while (!pll_off_req) @(negedge clk);
        pulse_wake();
        tick(40);
        check(vret_seen == 0, "R8 no supply request after wake in entry", vret_seen, 0);
        all_low("R8 returned to running");
        d_pll = 0;

        // zero target
        pulse_idle(0, 0);
        tick(5);
        check(halt == 0, "R9 target 0 ignored", halt, 0);

        // collision of idle and wake
        pulse_idle(3, 1);
        tick(5);
        check(halt == 0, "R9 wake wins over idle_req", halt, 0);

        // wake while running
        pulse_wake();
        tick(3);
        all_low("R9 wake while running ignored");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule